// File: doc/BRIEF.md
# Keyed-Feed Watchdog and Interval Timer

This block is a watchdog timer that can also serve as an interval timer. A 12-bit up-counting prescaler produces a decrement strobe for an 8-bit down counter. The strobe period is picked by a 3-bit select field. The prescaler is clocked either by the system clock divided by 32 or by an external slow-oscillator tick, and the source is chosen by a control bit. When the down counter underflows, the block reloads it and signals a timeout. In watchdog mode the timeout is a one-cycle system reset request. In interval mode it is a one-cycle interrupt pulse. In both modes a sticky timeout flag is set.

Software reloads the counter only through a keyed two-write feed: 0xA5 to the first key register, then 0x5A to the second key register as the very next bus write. Writes to the control register are held in a shadow copy, and that copy becomes active only on the next valid feed. In watchdog mode, a broken key sequence or a control write that is not followed at once by a feed raises the reset request. The timeout flag is kept across a system reset and is cleared only by the power-on reset or by software.

Top module: `wdt_keyfeed`

## Requirements
- R1: After `por`, address 0 (active control) and address 3 (shadow control) read 0xE4. The control byte layout is: select in bits 7:5 = 7, run in bit 2 = 1, flag in bit 1 = 0, source in bit 0 = 0 (0 = system clock / 32). The reload register (address 1) and the count (address 2) read 0xFF, and `rst_req`, `tmo_irq` and `tmo_flag` are low.
- R2: A valid feed loads the count from the reload register and restarts the prescaler and the divide-by-32 stage. A valid feed is 0xA5 written to address 2, with 0x5A written to address 3 as the next bus write. Idle cycles between the two writes are allowed.
- R3: A write to address 0 changes only the shadow control (read at address 3). The active control (address 0) keeps its old value until the next valid feed, which copies the shadow into it.
- R4: The count decrements once every 2^(sel+5) prescaler input ticks. With reload value R, the first underflow happens exactly (R+1)·2^(sel+5) ticks after the feed's second write edge, and the count then reloads from the reload register.
- R5: When `wdt_en` is 1, an underflow drives `rst_req` high for one cycle, registered on the underflow edge, and sets `tmo_flag`.
- R6: When `wdt_en` is 1, any of the following asserts `rst_req` in the cycle after the offending write:
  - a write to address 2 of a value other than 0xA5;
  - a write to address 3 that does not directly follow an accepted 0xA5 at address 2;
  - any write after an accepted 0xA5 other than 0x5A to address 3.
- R7: When `wdt_en` is 1, the write that follows a control write must be 0xA5 to address 2, otherwise `rst_req` asserts. With no control write pending, reload writes (address 1) are free.
- R8: When `wdt_en` is 0, an underflow sets `tmo_flag` and pulses `tmo_irq` for one cycle without asserting `rst_req`, and counting continues from the reload value. Sequence errors never assert `rst_req`.
- R9: `tmo_flag` is kept while `rst` is asserted. It is cleared at once by `por` or by a control write with bit 1 = 0; no feed is needed for the clear. A control write with bit 1 = 1 never sets the flag.
- R10: With source bit 0 = 0, the prescaler advances once per 32 clocks, and both the divider and the prescaler hold while `pd` is high. With bit 0 = 1, the prescaler advances on each `osc_tick` and `pd` has no effect.
- R11: With run bit 2 = 0, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por | input | 1 | Power-on reset, synchronous, active high; clears everything |
| rst | input | 1 | System reset, synchronous, active high; clears the feed sequence and the output pulses |
| wdt_en | input | 1 | 1 = watchdog mode (reset on timeout), 0 = interval mode |
| pd | input | 1 | Power-down indication; freezes the divided system-clock source |
| osc_tick | input | 1 | One-cycle tick from the slow watchdog oscillator |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 reload, 2 key 1, 3 key 2 |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address: 0 active control, 1 reload, 2 count, 3 shadow control |
| rd_data | output | 8 | Registered read data, valid one cycle after `rd_addr` |
| rst_req | output | 1 | One-cycle system reset request |
| tmo_irq | output | 1 | One-cycle interval interrupt |
| tmo_flag | output | 1 | Sticky timeout flag |

## Verification
Every result leaves a register on the clock edge that consumes its cause.

| Cause | Result | When it appears |
|-------|--------|-----------------|
| Bus write | `rst_req` for a sequence error, flag clear, shadow update | Right after that write's edge |
| Read | `rd_data` | One edge after `rd_addr` is set |
| Feed (second write edge) | Underflow (`rst_req`, `tmo_irq`, flag set) | (R+1)·2^(sel+5) prescaler ticks after the feed |
| Feed, system-clock source | Underflow | 32 times as many clocks, plus one cycle for each cycle `pd` was high |

The bench drives inputs and samples outputs on falling edges. For each timing check it counts edges from the feed. It confirms the output is still low one cycle before the due edge and high on the due edge. A pulse is also checked to be gone one cycle later.

// File: rtl/wdk_pkg.sv
package wdk_pkg;

  localparam int REG_W   = 8;
  localparam int SEL_W   = 3;
  localparam int ADDR_W  = 2;

  localparam logic [REG_W-1:0] KEY_FIRST  = 8'hA5;
  localparam logic [REG_W-1:0] KEY_SECOND = 8'h5A;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 2'd0,
    A_RELOAD = 2'd1,
    A_KEY1   = 2'd2,
    A_KEY2   = 2'd3
  } reg_addr_e;

  // Control fields; bit 1 (flag) lives outside the shadowed part.
  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             run;
    logic             src;
  } ctl_t;

  function automatic ctl_t ctl_from(input logic [REG_W-1:0] b);
    ctl_t c;
    c.sel = b[7:5];
    c.run = b[2];
    c.src = b[0];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] ctl_byte(input ctl_t c, input logic flag);
    return {c.sel, 2'b00, c.run, flag, c.src};
  endfunction

endpackage

// File: rtl/wdk_feed_seq.sv
module wdk_feed_seq
  import wdk_pkg::*;
(
  input  logic              clk,
  input  logic              srst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  output logic              feed_ok,
  output logic              seq_bad,
  output logic              pend
);

  logic armed;
  logic key1_hit;

  assign key1_hit = (wr_addr == A_KEY1) && (wr_data == KEY_FIRST);

  // Classify the current write against the sequence state.
  always_comb begin
    feed_ok = 1'b0;
    seq_bad = 1'b0;
    if (wr_en) begin
      if (armed) begin
        if ((wr_addr == A_KEY2) && (wr_data == KEY_SECOND)) feed_ok = 1'b1;
        else                                               seq_bad = 1'b1;
      end else if (wr_addr == A_KEY1) begin
        seq_bad = !key1_hit;
      end else if (wr_addr == A_KEY2) begin
        seq_bad = 1'b1;
      end else if (pend) begin
        seq_bad = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (srst) begin
      armed <= 1'b0;
      pend  <= 1'b0;
    end else if (wr_en) begin
      armed <= !armed && key1_hit;
      if (feed_ok)                 pend <= 1'b0;
      else if (wr_addr == A_CTRL)  pend <= 1'b1;
    end
  end

endmodule

// File: rtl/wdk_tick_gen.sv
module wdk_tick_gen
  import wdk_pkg::*;
#(
  parameter int PRE_W = 12,
  parameter int DIV_W = 5
) (
  input  logic             clk,
  input  logic             srst,
  input  logic             clr,
  input  logic             run,
  input  logic             src_osc,
  input  logic             pd,
  input  logic             osc_tick,
  input  logic [SEL_W-1:0] sel,
  output logic             dec
);

  localparam int N_TAP  = 1 << SEL_W;
  localparam int TAP_LO = PRE_W - N_TAP + 1;

  logic [DIV_W-1:0] div_q;
  logic [PRE_W-1:0] pre_q;
  logic [N_TAP-1:0] tap_hit;
  logic             src_tick;

  assign src_tick = src_osc ? osc_tick : ((&div_q) && !pd);

  // Tap k is hit when the low TAP_LO+k prescaler bits are all ones.
  for (genvar k = 0; k < N_TAP; k++) begin : g_tap
    assign tap_hit[k] = &pre_q[TAP_LO+k-1:0];
  end

  assign dec = run && src_tick && tap_hit[sel];

  always_ff @(posedge clk) begin
    if (srst || clr) begin
      div_q <= '0;
      pre_q <= '0;
    end else if (run) begin
      if (!pd)      div_q <= div_q + 1'b1;
      if (src_tick) pre_q <= pre_q + 1'b1;
    end
  end

endmodule

// File: rtl/wdk_downcnt.sv
module wdk_downcnt #(
  parameter int               CNT_W   = 8,
  parameter logic [CNT_W-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             srst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] count,
  output logic             uflow
);

  assign uflow = dec && !load && (count == '0);

  always_ff @(posedge clk) begin
    if (srst)               count <= RST_VAL;
    else if (load || uflow) count <= load_val;
    else if (dec)           count <= count - 1'b1;
  end

endmodule

// File: rtl/wdt_keyfeed.sv
module wdt_keyfeed
  import wdk_pkg::*;
#(
  parameter int               PRE_W      = 12,
  parameter int               DIV_W      = 5,
  parameter int               CNT_W      = 8,
  parameter logic [REG_W-1:0] RST_CTRL   = 8'hE4,
  parameter logic [CNT_W-1:0] RST_RELOAD = '1
) (
  input  logic              clk,
  input  logic              por,
  input  logic              rst,
  input  logic              wdt_en,
  input  logic              pd,
  input  logic              osc_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  output logic              rst_req,
  output logic              tmo_irq,
  output logic              tmo_flag
);

  logic             wr_go;
  logic             ctrl_wr;
  logic             feed_ok;
  logic             seq_bad;
  logic             pend;
  logic             dec;
  logic             uflow;
  ctl_t             act_ctl;
  ctl_t             sh_ctl;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] count_q;

  assign wr_go   = wr_en && !rst;
  assign ctrl_wr = wr_go && (wr_addr == A_CTRL);

  wdk_feed_seq u_seq (
    .clk     (clk),
    .srst    (por || rst),
    .wr_en   (wr_go),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .feed_ok (feed_ok),
    .seq_bad (seq_bad),
    .pend    (pend)
  );

  wdk_tick_gen #(
    .PRE_W (PRE_W),
    .DIV_W (DIV_W)
  ) u_tick (
    .clk      (clk),
    .srst     (por),
    .clr      (feed_ok),
    .run      (act_ctl.run),
    .src_osc  (act_ctl.src),
    .pd       (pd),
    .osc_tick (osc_tick),
    .sel      (act_ctl.sel),
    .dec      (dec)
  );

  wdk_downcnt #(
    .CNT_W   (CNT_W),
    .RST_VAL (RST_RELOAD)
  ) u_cnt (
    .clk      (clk),
    .srst     (por),
    .load     (feed_ok),
    .load_val (reload_q),
    .dec      (dec),
    .count    (count_q),
    .uflow    (uflow)
  );

  // Configuration state: survives rst, cleared only by por.
  always_ff @(posedge clk) begin
    if (por) begin
      act_ctl  <= ctl_from(RST_CTRL);
      sh_ctl   <= ctl_from(RST_CTRL);
      reload_q <= RST_RELOAD;
      tmo_flag <= 1'b0;
    end else begin
      if (ctrl_wr)                             sh_ctl   <= ctl_from(wr_data);
      if (wr_go && (wr_addr == A_RELOAD))      reload_q <= wr_data[CNT_W-1:0];
      if (feed_ok && pend)                     act_ctl  <= sh_ctl;
      if (uflow)                               tmo_flag <= 1'b1;
      else if (ctrl_wr && !wr_data[1])         tmo_flag <= 1'b0;
    end
  end

  // Event outputs, registered on the edge of their cause.
  always_ff @(posedge clk) begin
    if (por || rst) begin
      rst_req <= 1'b0;
      tmo_irq <= 1'b0;
    end else begin
      rst_req <= wdt_en && (seq_bad || uflow);
      tmo_irq <= !wdt_en && uflow;
    end
  end

  always_ff @(posedge clk) begin
    if (por) begin
      rd_data <= '0;
    end else begin
      unique case (rd_addr)
        A_CTRL:   rd_data <= ctl_byte(act_ctl, tmo_flag);
        A_RELOAD: rd_data <= REG_W'(reload_q);
        A_KEY1:   rd_data <= REG_W'(count_q);
        default:  rd_data <= ctl_byte(sh_ctl, tmo_flag);
      endcase
    end
  end

endmodule

// File: rtl/wdk_checker.sv
module wdk_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             por,
  input logic             wdt_en,
  input logic             wr_en,
  input logic             rst,
  input logic [1:0]       wr_addr,
  input logic [7:0]       wr_data,
  input logic             rst_req,
  input logic             tmo_irq,
  input logic             tmo_flag,
  input logic             feed_ok,
  input logic             pend,
  input logic [4:0]       act_bits,
  input logic [CNT_W-1:0] count_q,
  input logic [CNT_W-1:0] reload_q
);

  // R2: a valid feed puts the reload value into the counter
  a_r2_feed_loads: assert property (@(posedge clk) disable iff (por)
    feed_ok |=> (count_q == $past(reload_q)));

  // R3: active control moves only on a feed with a pending shadow
  a_r3_active_held: assert property (@(posedge clk) disable iff (por)
    !(feed_ok && pend) |=> $stable(act_bits));

  // R5: the flag rises only together with a timeout event
  a_r5_flag_with_event: assert property (@(posedge clk) disable iff (por)
    $rose(tmo_flag) |-> (rst_req || tmo_irq));

  // R8: interrupt only in interval mode, one cycle wide
  a_r8_irq_interval: assert property (@(posedge clk) disable iff (por)
    tmo_irq |-> $past(!wdt_en));

  a_r8_irq_pulse: assert property (@(posedge clk) disable iff (por)
    tmo_irq |=> !tmo_irq);

  // R9: flag stays set unless cleared by a control write with bit 1 low
  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (por)
    (tmo_flag && !(wr_en && !rst && wr_addr == 2'd0 && !wr_data[1])) |=> tmo_flag);

  // R11: stopped counter holds its value
  a_r11_halt: assert property (@(posedge clk) disable iff (por)
    (!act_bits[1] && !feed_ok) |=> $stable(count_q));

endmodule

bind wdt_keyfeed wdk_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .por      (por),
  .wdt_en   (wdt_en),
  .wr_en    (wr_en),
  .rst      (rst),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .rst_req  (rst_req),
  .tmo_irq  (tmo_irq),
  .tmo_flag (tmo_flag),
  .feed_ok  (feed_ok),
  .pend     (pend),
  .act_bits (act_ctl),
  .count_q  (count_q),
  .reload_q (reload_q)
);

// File: tb/wdt_keyfeed_tb.sv
`timescale 1ns/1ps
module wdt_keyfeed_tb;

  logic       clk = 1'b0;
  logic       por = 1'b1;
  logic       rst = 1'b0;
  logic       wdt_en = 1'b1;
  logic       pd = 1'b0;
  logic       osc_tick = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [1:0] rd_addr = 2'd0;
  logic [7:0] rd_data;
  logic       rst_req;
  logic       tmo_irq;
  logic       tmo_flag;

  int errors = 0;
  int checks = 0;
  int irq_cnt = 0;
  logic [7:0] v;

  always #4 clk = ~clk;

  wdt_keyfeed u_dut (
    .clk(clk), .por(por), .rst(rst), .wdt_en(wdt_en), .pd(pd),
    .osc_tick(osc_tick), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .rst_req(rst_req),
    .tmo_irq(tmo_irq), .tmo_flag(tmo_flag)
  );

  always @(negedge clk) if (tmo_irq) irq_cnt++;

  // {addr[1:0], data[7:0], expect_reset} in watchdog mode
  localparam logic [10:0] VEC [14] = '{
    {2'd2, 8'hA5, 1'b0}, {2'd3, 8'h5A, 1'b0}, {2'd2, 8'hA4, 1'b1},
    {2'd3, 8'h5A, 1'b1}, {2'd2, 8'hA5, 1'b0}, {2'd1, 8'h10, 1'b1},
    {2'd1, 8'h10, 1'b0}, {2'd0, 8'hE4, 1'b0}, {2'd1, 8'h10, 1'b1},
    {2'd2, 8'hA5, 1'b0}, {2'd3, 8'h5B, 1'b1}, {2'd0, 8'hE4, 1'b0},
    {2'd2, 8'hA5, 1'b0}, {2'd3, 8'h5A, 1'b0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] val);
    rd_addr = a;
    @(posedge clk); @(negedge clk);
    val = rd_data;
  endtask

  task automatic feed();
    wr(2'd2, 8'hA5);
    wr(2'd3, 8'h5A);
  endtask

  task automatic pulse_rst();
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    por = 1'b0;

    // R1 reset state
    chk("R1 rst_req", rst_req, 0);
    chk("R1 tmo_irq", tmo_irq, 0);
    chk("R1 tmo_flag", tmo_flag, 0);
    rd(2'd0, v); chk("R1 active ctrl", v, 8'hE4);
    rd(2'd1, v); chk("R1 reload", v, 8'hFF);
    rd(2'd2, v); chk("R1 count", v, 8'hFF);
    rd(2'd3, v); chk("R1 shadow ctrl", v, 8'hE4);

    // R6/R7 sequence table
    for (int i = 0; i < 14; i++) begin
      wr(VEC[i][10:9], VEC[i][8:1]);
      chk($sformatf("R6/R7 row %0d rst_req", i), rst_req, VEC[i][0]);
      if (VEC[i][0]) pulse_rst();
    end
    rd(2'd2, v); chk("R2 count after feed", v, 8'h10);
    rd(2'd1, v); chk("R2 reload value", v, 8'h10);

    // R3 shadowing
    wr(2'd0, 8'h25);
    rd(2'd3, v); chk("R3 shadow holds write", v, 8'h25);
    rd(2'd0, v); chk("R3 active unchanged", v, 8'hE4);
    feed();
    rd(2'd0, v); chk("R3 active after feed", v, 8'h25);

    // R4 / R5 watchdog timeout: reload 2, sel 0, osc source
    wr(2'd1, 8'h02);
    wr(2'd0, 8'h05);
    feed();
    wait_cyc(39);
    rd(2'd2, v); chk("R4 count after one tap", v, 8'h01);
    wait_cyc(55);
    chk("R4 no early underflow", rst_req, 0);
    wait_cyc(1);
    chk("R5 reset on underflow", rst_req, 1);
    chk("R5 flag set", tmo_flag, 1);
    pulse_rst();
    chk("R9 flag kept over rst", tmo_flag, 1);
    chk("R5 reset request cleared", rst_req, 0);
    wdt_en = 1'b0;

    // R9 flag clearing
    wr(2'd0, 8'h05);
    chk("R9 flag cleared by write of 0", tmo_flag, 0);
    wr(2'd0, 8'h07);
    chk("R9 write of 1 does not set", tmo_flag, 0);
    chk("R8 unfed ctrl no reset", rst_req, 0);
    wr(2'd2, 8'h11);
    chk("R8 bad key no reset", rst_req, 0);

    // R8 interval mode
    wr(2'd1, 8'h02);
    wr(2'd0, 8'h05);
    feed();
    wait_cyc(95);
    chk("R8 no early irq", tmo_irq, 0);
    wait_cyc(1);
    chk("R8 irq on underflow", tmo_irq, 1);
    chk("R8 no reset in interval mode", rst_req, 0);
    chk("R8 flag set", tmo_flag, 1);
    wait_cyc(1);
    chk("R8 irq one cycle", tmo_irq, 0);
    wait_cyc(94);
    chk("R8 second period not early", tmo_irq, 0);
    wait_cyc(1);
    chk("R8 second period irq", tmo_irq, 1);

    // R11 run bit clear
    wr(2'd0, 8'h01);
    feed();
    irq_cnt = 0;
    wait_cyc(200);
    chk("R11 no irq while stopped", irq_cnt, 0);
    rd(2'd2, v); chk("R11 count held", v, 8'h02);

    // R10 system clock / 32 source
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h04);
    feed();
    wait_cyc(1023);
    chk("R10 div32 not early", tmo_irq, 0);
    wait_cyc(1);
    chk("R10 div32 underflow", tmo_irq, 1);

    feed();
    wait_cyc(10);
    pd = 1'b1;
    wait_cyc(100);
    pd = 1'b0;
    wait_cyc(1013);
    chk("R10 pd stretches period", tmo_irq, 0);
    wait_cyc(1);
    chk("R10 irq after pd delay", tmo_irq, 1);

    wr(2'd1, 8'h02);
    wr(2'd0, 8'h05);
    pd = 1'b1;
    feed();
    wait_cyc(95);
    chk("R10 osc source pd no early", tmo_irq, 0);
    wait_cyc(1);
    chk("R10 osc source ignores pd", tmo_irq, 1);
    pd = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule